// File: doc/BRIEF.md
# Write Drain Watermark Controller

This block sits beside the read and write queues of a memory controller and decides when the shared data bus stops serving reads and starts emptying buffered writes. It compares the write-queue occupancy against two watermarks. Both are derived from the write buffer depth as whole-number percentages. When the high mark is crossed it holds off read scheduling. It then waits for the data bus to go idle and inserts a fixed read-to-write turnaround before it grants the write batch. While the batch runs it counts the writes the queue logic reports as issued. When occupancy drops to the low mark the batch ends and reads resume.

The block also handles two things at the queue edge. First, an incoming read address is compared against every valid pending write. A match means the read is answered from the write queue, so only the frontend latency applies. A miss goes to memory and carries frontend plus backend latency. Second, a write offered while the write queue is full is refused with a retry flag. The flag drops once space frees.

Top module: `wdw_ctrl`

## Requirements
- R1: After reset, stop_reads, drain_grant, wr_retry and rd_fwd_hit are 0, and drain_writes and rd_latency are 0.
- R2: The high mark is HIGH = floor(WQ_DEPTH*HIGH_PCT/100), which is 6 by default. stop_reads rises in the cycle after a clock edge samples wq_occ > HIGH while reads are being served. An occupancy equal to HIGH or below does not raise it.
- R3: Once stop_reads is high, drain_grant stays low while bus_busy is sampled high. drain_grant rises TURN_CYC+1 clock edges after the first edge that samples bus_busy low, counting that edge. By default this is 4 edges.
- R4: drain_writes is cleared when a drain starts, meaning on the edge that raises stop_reads. Each edge that samples wr_issued high while drain_grant is high increments it by one.
- R5: The low mark is LOW = floor(WQ_DEPTH*LOW_PCT/100), which is 2 by default, and it is forced strictly below HIGH. An edge that samples wq_occ <= LOW while drain_grant is high clears both drain_grant and stop_reads in the next cycle. drain_writes then holds its final value.
- R6: drain_grant is never high unless stop_reads is high.
- R7: One cycle after an edge that samples rd_lookup_valid high, the block reports the result of the lookup. On a match against a valid write entry (entry i occupies wq_addr bits [i*ADDR_W +: ADDR_W]), rd_fwd_hit is 1, rd_fwd_idx is the lowest matching index and rd_latency is FE_LAT, which is 2 by default.
- R8: One cycle after a lookup with no match, rd_fwd_hit is 0 and rd_latency is FE_LAT+BE_LAT, which is 7 by default. Entries whose wq_valid bit is 0 never match. After an edge with no lookup, rd_fwd_hit and rd_latency are 0.
- R9: An edge that samples wr_arrive high while wq_occ == WQ_DEPTH sets wr_retry in the next cycle. wr_retry stays set while wq_occ == WQ_DEPTH. It clears in the cycle after an edge that samples wq_occ < WQ_DEPTH. A full queue with no arriving write does not set it.
- R10: wr_issued pulses while drain_grant is low leave drain_writes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wq_occ | input | CNT_W | Current write-queue occupancy, 0 to WQ_DEPTH |
| bus_busy | input | 1 | Data bus still carrying read data |
| wr_issued | input | 1 | One buffered write was sent to memory this cycle |
| wr_arrive | input | 1 | A new write is offered to the write queue |
| rd_lookup_valid | input | 1 | An incoming read address is presented for lookup |
| rd_lookup_addr | input | ADDR_W | Address of the incoming read |
| wq_valid | input | WQ_DEPTH | Valid bit of each write-queue entry |
| wq_addr | input | WQ_DEPTH*ADDR_W | Packed addresses of the write-queue entries |
| stop_reads | output | 1 | Read scheduling held off |
| drain_grant | output | 1 | Write batch may issue |
| drain_writes | output | DRAIN_W | Writes issued in the current or last drain |
| wr_retry | output | 1 | Offered write refused; retry when space frees |
| rd_fwd_hit | output | 1 | Last lookup is served from the write queue |
| rd_fwd_idx | output | IDX_W | Entry that serves the last lookup |
| rd_latency | output | LAT_W | Latency class of the last lookup |

## Verification
A wrong drain state shows up at the ports within one cycle. stop_reads and drain_grant come straight from the state register, so a missed watermark crossing, a turnaround counter that is off by one or a sticky drain state shifts their edges by a whole number of cycles against a count the bench computes. A bad batch counter appears at drain_writes on the edge after the write pulse it mishandled. A bad compare or priority appears at rd_fwd_hit, rd_fwd_idx and rd_latency one cycle after the lookup. This is checked over every valid mask with duplicated addresses.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [1:0] {
        ST_READ     = 2'd0,
        ST_WAIT_BUS = 2'd1,
        ST_TURN     = 2'd2,
        ST_DRAIN    = 2'd3
    } drain_st_e;

    function automatic int pct_of(input int depth, input int pct);
        return (depth * pct) / 100;
    endfunction

endpackage

// File: rtl/wdw_addr_match.sv
module wdw_addr_match #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [DEPTH-1:0]        valid,
    input  logic [DEPTH*ADDR_W-1:0] addr_flat,
    input  logic [ADDR_W-1:0]       key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);

    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid[g] && (addr_flat[g*ADDR_W +: ADDR_W] == key);
    end

    // lowest matching entry wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/wdw_drain_fsm.sv
module wdw_drain_fsm
    import wdw_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int DRAIN_W  = 8,
    parameter int HIGH     = 6,
    parameter int LOW      = 2,
    parameter int TURN_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   wq_occ,
    input  logic               bus_busy,
    input  logic               wr_issued,
    output logic               stop_reads,
    output logic               drain_grant,
    output logic [DRAIN_W-1:0] drain_writes
);

    localparam int TURN_W = $clog2(TURN_CYC + 1);

    typedef struct packed {
        drain_st_e          st;
        logic [TURN_W-1:0]  turn;
        logic [DRAIN_W-1:0] cnt;
    } fsm_t;

    fsm_t s_d, s_q;
    logic above_high, at_low;

    assign above_high = int'(wq_occ) > HIGH;
    assign at_low     = int'(wq_occ) <= LOW;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_READ: begin
                if (above_high) begin
                    s_d.st  = ST_WAIT_BUS;
                    s_d.cnt = '0;
                end
            end
            ST_WAIT_BUS: begin
                if (!bus_busy) begin
                    s_d.st   = ST_TURN;
                    s_d.turn = TURN_W'(TURN_CYC);
                end
            end
            ST_TURN: begin
                if (s_q.turn <= TURN_W'(1)) begin
                    s_d.st = ST_DRAIN;
                end else begin
                    s_d.turn = s_q.turn - TURN_W'(1);
                end
            end
            ST_DRAIN: begin
                if (wr_issued) begin
                    s_d.cnt = s_q.cnt + DRAIN_W'(1);
                end
                if (at_low) begin
                    s_d.st = ST_READ;
                end
            end
            default: s_d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_READ, turn: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign stop_reads   = (s_q.st != ST_READ);
    assign drain_grant  = (s_q.st == ST_DRAIN);
    assign drain_writes = s_q.cnt;

endmodule

// File: rtl/wdw_retry_track.sv
module wdw_retry_track #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] wq_occ,
    input  logic             wr_arrive,
    output logic             wr_retry
);

    logic retry_d, retry_q;
    logic full;

    assign full = int'(wq_occ) >= DEPTH;

    always_comb begin
        retry_d = full && (wr_arrive || retry_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q <= 1'b0;
        end else begin
            retry_q <= retry_d;
        end
    end

    assign wr_retry = retry_q;

endmodule

// File: rtl/wdw_ctrl.sv
module wdw_ctrl
    import wdw_pkg::*;
#(
    parameter int WQ_DEPTH = 8,
    parameter int ADDR_W   = 8,
    parameter int HIGH_PCT = 75,
    parameter int LOW_PCT  = 25,
    parameter int TURN_CYC = 3,
    parameter int FE_LAT   = 2,
    parameter int BE_LAT   = 5,
    parameter int DRAIN_W  = 8,
    localparam int CNT_W   = $clog2(WQ_DEPTH + 1),
    localparam int IDX_W   = (WQ_DEPTH > 1) ? $clog2(WQ_DEPTH) : 1,
    localparam int LAT_W   = $clog2(FE_LAT + BE_LAT + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           wq_occ,
    input  logic                       bus_busy,
    input  logic                       wr_issued,
    input  logic                       wr_arrive,
    input  logic                       rd_lookup_valid,
    input  logic [ADDR_W-1:0]          rd_lookup_addr,
    input  logic [WQ_DEPTH-1:0]        wq_valid,
    input  logic [WQ_DEPTH*ADDR_W-1:0] wq_addr,
    output logic                       stop_reads,
    output logic                       drain_grant,
    output logic [DRAIN_W-1:0]         drain_writes,
    output logic                       wr_retry,
    output logic                       rd_fwd_hit,
    output logic [IDX_W-1:0]           rd_fwd_idx,
    output logic [LAT_W-1:0]           rd_latency
);

    localparam int HIGH_THR = pct_of(WQ_DEPTH, HIGH_PCT);
    localparam int LOW_RAW  = pct_of(WQ_DEPTH, LOW_PCT);
    localparam int LOW_THR  = (LOW_RAW >= HIGH_THR) ? HIGH_THR - 1 : LOW_RAW;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [LAT_W-1:0] lat;
    } lkp_t;

    lkp_t lk_d, lk_q;
    logic             m_hit;
    logic [IDX_W-1:0] m_idx;

    wdw_drain_fsm #(
        .CNT_W   (CNT_W),
        .DRAIN_W (DRAIN_W),
        .HIGH    (HIGH_THR),
        .LOW     (LOW_THR),
        .TURN_CYC(TURN_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wq_occ      (wq_occ),
        .bus_busy    (bus_busy),
        .wr_issued   (wr_issued),
        .stop_reads  (stop_reads),
        .drain_grant (drain_grant),
        .drain_writes(drain_writes)
    );

    wdw_retry_track #(
        .DEPTH(WQ_DEPTH),
        .CNT_W(CNT_W)
    ) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .wq_occ   (wq_occ),
        .wr_arrive(wr_arrive),
        .wr_retry (wr_retry)
    );

    wdw_addr_match #(
        .DEPTH (WQ_DEPTH),
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_match (
        .valid    (wq_valid),
        .addr_flat(wq_addr),
        .key      (rd_lookup_addr),
        .hit      (m_hit),
        .idx      (m_idx)
    );

    always_comb begin
        lk_d = '0;
        if (rd_lookup_valid) begin
            lk_d.hit = m_hit;
            lk_d.idx = m_hit ? m_idx : '0;
            lk_d.lat = m_hit ? LAT_W'(FE_LAT) : LAT_W'(FE_LAT + BE_LAT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign rd_fwd_hit = lk_q.hit;
    assign rd_fwd_idx = lk_q.idx;
    assign rd_latency = lk_q.lat;

endmodule

// File: rtl/wdw_ctrl_chk.sv
module wdw_ctrl_chk #(
    parameter int DEPTH   = 8,
    parameter int CNT_W   = 4,
    parameter int DRAIN_W = 8,
    parameter int LAT_W   = 3,
    parameter int HIGH    = 6,
    parameter int LOW     = 2,
    parameter int FE_LAT  = 2,
    parameter int BE_LAT  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   wq_occ,
    input logic               wr_issued,
    input logic               wr_arrive,
    input logic               rd_lookup_valid,
    input logic               stop_reads,
    input logic               drain_grant,
    input logic [DRAIN_W-1:0] drain_writes,
    input logic               wr_retry,
    input logic               rd_fwd_hit,
    input logic [LAT_W-1:0]   rd_latency
);

    p_rise_needs_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_reads) |-> int'($past(wq_occ)) > HIGH);

    p_grant_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_grant) |-> $past(stop_reads));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drain_grant && wr_issued |=> drain_writes == $past(drain_writes) + DRAIN_W'(1));

    p_drain_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drain_grant && int'(wq_occ) <= LOW |=> !drain_grant && !stop_reads);

    p_grant_needs_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drain_grant |-> stop_reads);

    p_hit_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fwd_hit |-> rd_latency == LAT_W'(FE_LAT));

    p_miss_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lookup_valid |=> rd_fwd_hit || rd_latency == LAT_W'(FE_LAT + BE_LAT));

    p_retry_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_arrive && int'(wq_occ) == DEPTH |=> wr_retry);

    p_retry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wq_occ) < DEPTH |=> !wr_retry);

    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_reads && !drain_grant |=> $stable(drain_writes));

endmodule

bind wdw_ctrl wdw_ctrl_chk #(
    .DEPTH  (WQ_DEPTH),
    .CNT_W  (CNT_W),
    .DRAIN_W(DRAIN_W),
    .LAT_W  (LAT_W),
    .HIGH   (HIGH_THR),
    .LOW    (LOW_THR),
    .FE_LAT (FE_LAT),
    .BE_LAT (BE_LAT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wq_occ         (wq_occ),
    .wr_issued      (wr_issued),
    .wr_arrive      (wr_arrive),
    .rd_lookup_valid(rd_lookup_valid),
    .stop_reads     (stop_reads),
    .drain_grant    (drain_grant),
    .drain_writes   (drain_writes),
    .wr_retry       (wr_retry),
    .rd_fwd_hit     (rd_fwd_hit),
    .rd_latency     (rd_latency)
);

// File: tb/wdw_ctrl_test.sv
module wdw_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int AW     = 8;
    localparam int HIGH   = (DEPTH * 75) / 100;
    localparam int LOW    = (DEPTH * 25) / 100;
    localparam int TURN   = 3;
    localparam int FE     = 2;
    localparam int BE     = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      wq_occ = '0;
    logic            bus_busy = 1'b0;
    logic            wr_issued = 1'b0;
    logic            wr_arrive = 1'b0;
    logic            rd_lookup_valid = 1'b0;
    logic [AW-1:0]   rd_lookup_addr = '0;
    logic [DEPTH-1:0] wq_valid = '0;
    logic [DEPTH*AW-1:0] wq_addr = '0;
    logic            stop_reads, drain_grant, wr_retry, rd_fwd_hit;
    logic [7:0]      drain_writes;
    logic [2:0]      rd_fwd_idx;
    logic [2:0]      rd_latency;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdw_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wq_occ(wq_occ), .bus_busy(bus_busy),
        .wr_issued(wr_issued), .wr_arrive(wr_arrive),
        .rd_lookup_valid(rd_lookup_valid), .rd_lookup_addr(rd_lookup_addr),
        .wq_valid(wq_valid), .wq_addr(wq_addr),
        .stop_reads(stop_reads), .drain_grant(drain_grant),
        .drain_writes(drain_writes), .wr_retry(wr_retry),
        .rd_fwd_hit(rd_fwd_hit), .rd_fwd_idx(rd_fwd_idx),
        .rd_latency(rd_latency)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wq_occ = '0; bus_busy = 1'b0; wr_issued = 1'b0; wr_arrive = 1'b0;
        rd_lookup_valid = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 stop_reads", int'(stop_reads), 0);
        check("R1 drain_grant", int'(drain_grant), 0);
        check("R1 drain_writes", int'(drain_writes), 0);
        check("R1 wr_retry", int'(wr_retry), 0);
        check("R1 rd_fwd_hit", int'(rd_fwd_hit), 0);
        check("R1 rd_latency", int'(rd_latency), 0);

        // R2 watermark sweep over every occupancy
        for (int o = 0; o <= DEPTH; o++) begin
            do_reset();
            bus_busy = 1'b1;
            wq_occ = 4'(o);
            tick();
            check("R2 stop_reads vs occupancy", int'(stop_reads), (o > HIGH) ? 1 : 0);
            check("R6 no grant before turnaround", int'(drain_grant), 0);
        end

        // R3 bus wait then turnaround
        do_reset();
        bus_busy = 1'b1;
        wq_occ = 4'(HIGH + 1);
        tick();
        check("R3 stop raised", int'(stop_reads), 1);
        check("R4 count cleared at start", int'(drain_writes), 0);
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R3 grant held while bus busy", int'(drain_grant), 0);
        end
        bus_busy = 1'b0;
        for (int k = 1; k <= TURN + 1; k++) begin
            tick();
            check("R3 grant after turnaround", int'(drain_grant), (k == TURN + 1) ? 1 : 0);
            check("R6 stop held", int'(stop_reads), 1);
        end

        // R4 count issued writes, with gaps
        for (int k = 0; k < 4; k++) begin
            wq_occ = 4'(HIGH + 1 - k);
            wr_issued = 1'b1;
            tick();
            check("R4 count step", int'(drain_writes), k + 1);
            wr_issued = 1'b0;
            tick();
            check("R4 count hold on gap", int'(drain_writes), k + 1);
        end
        wq_occ = 4'(LOW + 1);
        tick();
        check("R5 still draining above low", int'(drain_grant), 1);

        // R5 exit at low mark
        wq_occ = 4'(LOW);
        tick();
        check("R5 grant cleared", int'(drain_grant), 0);
        check("R5 stop cleared", int'(stop_reads), 0);
        check("R5 count kept", int'(drain_writes), 4);

        // R10 issue pulses outside a drain
        for (int k = 0; k < 3; k++) begin
            wr_issued = 1'b1;
            tick();
        end
        wr_issued = 1'b0;
        check("R10 count unchanged outside drain", int'(drain_writes), 4);

        // R4 new drain clears count
        wq_occ = 4'(DEPTH);
        bus_busy = 1'b1;
        tick();
        check("R4 count cleared on new drain", int'(drain_writes), 0);
        wq_occ = 4'(0);
        bus_busy = 1'b0;
        for (int k = 0; k < TURN + 1; k++) tick();
        check("R5 empty queue drain granted", int'(drain_grant), 1);
        tick();
        check("R5 empty queue ends drain", int'(stop_reads), 0);

        // R9 retry on full
        do_reset();
        bus_busy = 1'b1;
        wq_occ = 4'(DEPTH);
        tick();
        check("R9 full without arrival", int'(wr_retry), 0);
        wr_arrive = 1'b1;
        tick();
        check("R9 retry set", int'(wr_retry), 1);
        wr_arrive = 1'b0;
        tick();
        check("R9 retry held while full", int'(wr_retry), 1);
        wq_occ = 4'(DEPTH - 1);
        tick();
        check("R9 retry cleared", int'(wr_retry), 0);
        wr_arrive = 1'b1;
        tick();
        check("R9 no retry with space", int'(wr_retry), 0);
        wr_arrive = 1'b0;

        // R7 / R8 lookup sweep over every valid mask
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            wq_addr[i*AW +: AW] = (i == 5) ? 8'h22 : AW'(8'h20 + i);
        end
        for (int m = 0; m < (1 << DEPTH); m++) begin
            for (int kk = 0; kk < 4; kk++) begin
                logic [AW-1:0] key;
                int exp_idx;
                key = (kk == 0) ? 8'h22 : (kk == 1) ? 8'h27 : (kk == 2) ? 8'h25 : 8'h99;
                exp_idx = -1;
                for (int i = DEPTH - 1; i >= 0; i--) begin
                    if (m[i] && wq_addr[i*AW +: AW] == key) exp_idx = i;
                end
                wq_valid = DEPTH'(m);
                rd_lookup_addr = key;
                rd_lookup_valid = 1'b1;
                tick();
                if (exp_idx >= 0) begin
                    check("R7 forward hit", int'(rd_fwd_hit), 1);
                    check("R7 lowest index", int'(rd_fwd_idx), exp_idx);
                    check("R7 frontend latency", int'(rd_latency), FE);
                end else begin
                    check("R8 miss", int'(rd_fwd_hit), 0);
                    check("R8 full latency", int'(rd_latency), FE + BE);
                end
            end
        end
        rd_lookup_valid = 1'b0;
        tick();
        check("R8 idle hit", int'(rd_fwd_hit), 0);
        check("R8 idle latency", int'(rd_latency), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule